// File: doc/BRIEF.md
# Watchdog Timer with Reset or Exception Response

This block guards a processor against software that has stopped making progress. A counter advances on every system clock cycle while the watchdog is enabled. Software must restart the counter (a "kick") before it reaches the selected period. If it does not, the block raises a one-cycle request to the chip's reset generator or, if configured, a one-cycle exception request to the interrupt controller. An exception leaves memory untouched, which helps with debugging.

The period is a power of two. A 4-bit select field chooses 2^(BASE_LOG2+n) cycles. Settings above PS_MAX behave as PS_MAX. With the default BASE_LOG2 of 13 and a 1 MHz clock, the range runs from about 8 ms to about 16.8 s. Every reset and every wake event puts the watchdog back in its safe state: enabled, longest period, reset response, counting from zero. Counting freezes while the chip sleeps or while a debugger halts the CPU. It resumes on its own when the pause ends. A low-power doze state is not an input, so counting continues through it.

A sticky flag records that the watchdog fired. It is cleared only by power-on reset or by a software write-one-to-clear. The reset that the watchdog itself requested leaves it unchanged, so software can find the cause after the restart. Software reaches the block through a simple write strobe and read strobe port with a 2-bit address.

Top module: `wdt_core`

## Requirements
- R1: After por_n or rst_n is released, and on the clock edge where wake_i is high, the control register (address 0) reads 0xB1: enable bit 0 = 1, response bit 1 = 0, select bits 7:4 = PS_MAX (11). The count restarts from zero, so the first request comes 2^(BASE_LOG2+PS_MAX) cycles later.
- R2: With select value n, a request is raised exactly 2^(BASE_LOG2+min(n,PS_MAX)) running cycles after the last restart. Select values above PS_MAX give the same period as PS_MAX. The select field reads back as written.
- R3: Any write to address 1 restarts the count. Kicks spaced closer than the period prevent every request.
- R4: With response bit 1 = 0, expiry gives a one-cycle pulse on rst_req_o and exc_req_o stays low.
- R5: With response bit 1 = 1, expiry gives a one-cycle pulse on exc_req_o and rst_req_o stays low.
- R6: Expiry sets the status flag (address 2, bit 0). Writing 1 to that bit clears it. rst_n leaves it unchanged and por_n clears it.
- R7: With enable bit 0 = 0, no request is raised and the count is held at zero. After enabling, the full period runs from the enabling write.
- R8: While sleep_i or dbg_halt_i is high, the count is frozen and no request is raised. When both are low again, counting resumes from where it stopped.
- R9: A control write that changes the select field restarts the count. A control write that keeps the same select value does not.
- R10: rd_data_o is updated one clock after a read strobe. Addresses 1 and 3 read as zero.
- R11: After an expiry, the count restarts from zero, so without a kick the next request follows one period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one count per cycle |
| rst_n | input | 1 | Chip reset, active low; resets control and count, keeps the status flag |
| por_n | input | 1 | Power-on reset, active low; resets everything |
| wake_i | input | 1 | Pulse on wake from sleep; restores safe defaults |
| sleep_i | input | 1 | High while the chip sleeps; freezes counting |
| dbg_halt_i | input | 1 | High while a debugger halts the CPU; freezes counting |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 kick, 2 status |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Registered read data |
| rst_req_o | output | 1 | One-cycle chip reset request |
| exc_req_o | output | 1 | One-cycle exception request |

## Verification
The assertions assume that BASE_LOG2 is at least 1, so two expiries can never fall on adjacent cycles. They also assume that the pause inputs and the wake pulse are synchronous to clk. The stimulus keeps to these assumptions: it uses BASE_LOG2 = 2 and changes every input half a cycle away from the active edge. Kick spacing, pause lengths and rewrite points are always chosen well inside the active period, so that each measured expiry time can be derived by plain arithmetic from the restart cycle.

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int BASE_LOG2 = 13,
  parameter int PS_MAX    = 11,
  parameter int SEL_W     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       wake_i,
  input  logic       sleep_i,
  input  logic       dbg_halt_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  input  logic [1:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       rst_req_o,
  output logic       exc_req_o
);

  localparam int MAIN_W = (PS_MAX > 0) ? PS_MAX : 1;
  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(PS_MAX);

  logic                 arst_n;
  logic                 en_q, exc_q, fired_q;
  logic [SEL_W-1:0]     sel_q, sel_eff, sel_new;
  logic [BASE_LOG2-1:0] pre_q;
  logic [MAIN_W-1:0]    main_q, lim;
  logic                 wr_ctrl, wr_kick, wr_stat;
  logic                 run, pre_top, expire, restart;

  assign arst_n  = rst_n & por_n;
  assign wr_ctrl = wr_en_i && (wr_addr_i == 2'd0);
  assign wr_kick = wr_en_i && (wr_addr_i == 2'd1);
  assign wr_stat = wr_en_i && (wr_addr_i == 2'd2);
  assign sel_new = wr_data_i[7:4];

  assign sel_eff = (sel_q > SEL_TOP) ? SEL_TOP : sel_q;
  assign lim     = {MAIN_W{1'b1}} >> (SEL_TOP - sel_eff);
  assign run     = en_q & ~sleep_i & ~dbg_halt_i;
  assign pre_top = &pre_q;
  assign expire  = run & pre_top & (main_q == lim);
  assign restart = wake_i | wr_kick | (wr_ctrl && sel_new != sel_q) | ~en_q | expire;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      en_q  <= 1'b1;
      exc_q <= 1'b0;
      sel_q <= SEL_TOP;
    end else if (wake_i) begin
      en_q  <= 1'b1;
      exc_q <= 1'b0;
      sel_q <= SEL_TOP;
    end else if (wr_ctrl) begin
      en_q  <= wr_data_i[0];
      exc_q <= wr_data_i[1];
      sel_q <= sel_new;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pre_q  <= '0;
      main_q <= '0;
    end else if (restart) begin
      pre_q  <= '0;
      main_q <= '0;
    end else if (run) begin
      pre_q <= pre_q + 1'b1;
      if (pre_top) main_q <= main_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_req_o <= 1'b0;
      exc_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire & ~exc_q;
      exc_req_o <= expire & exc_q;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      fired_q <= 1'b0;
    else if (expire)                 fired_q <= 1'b1;
    else if (wr_stat && wr_data_i[0]) fired_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rd_data_o <= '0;
    else if (rd_en_i) begin
      case (rd_addr_i)
        2'd0:    rd_data_o <= {sel_q, 2'b00, exc_q, en_q};
        2'd2:    rd_data_o <= {7'd0, fired_q};
        default: rd_data_o <= '0;
      endcase
    end
  end

endmodule

module wdt_core_chk (
  input logic clk,
  input logic rst_n,
  input logic por_n,
  input logic sleep_i,
  input logic dbg_halt_i,
  input logic en_q,
  input logic fired_q,
  input logic rst_req_o,
  input logic exc_req_o
);

  // R4
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !(rst_req_o && exc_req_o));

  // R4
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req_o |=> !rst_req_o);

  // R5
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    exc_req_o |=> !exc_req_o);

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rst_req_o || exc_req_o) |-> fired_q);

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !en_q |=> !(rst_req_o || exc_req_o));

  // R8
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (sleep_i || dbg_halt_i) |=> !(rst_req_o || exc_req_o));

endmodule

bind wdt_core wdt_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .por_n     (por_n),
  .sleep_i   (sleep_i),
  .dbg_halt_i(dbg_halt_i),
  .en_q      (en_q),
  .fired_q   (fired_q),
  .rst_req_o (rst_req_o),
  .exc_req_o (exc_req_o)
);

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
  localparam int BL = 2;
  localparam int PM = 11;

  logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0;
  logic wake = 1'b0, sleep = 1'b0, halt = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic rst_req, exc_req;
  int cyc = 0, req_cnt = 0, total = 0, bad = 0;
  bit done = 1'b0;

  wdt_core #(.BASE_LOG2(BL), .PS_MAX(PM)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wake_i(wake), .sleep_i(sleep),
    .dbg_halt_i(halt), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rst_req_o(rst_req), .exc_req_o(exc_req));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_req || exc_req) req_cnt <= req_cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic int period(input int s);
    return 1 << (BL + ((s > PM) ? PM : s));
  endfunction

  task automatic wait_req(input int t0, input int p, input bit exc, input string tag,
                          output int tdet);
    while (!(rst_req || exc_req) && (cyc - t0) <= 2 * p + 8) @(negedge clk);
    tdet = cyc;
    chk(cyc - t0 == p, {tag, " period"}, cyc - t0, p);
    chk(exc_req == exc && rst_req == !exc, {tag, " request kind"},
        {30'd0, exc_req, rst_req}, exc ? 2 : 1);
    @(negedge clk);
    chk(!rst_req && !exc_req, {tag, " single pulse"}, {30'd0, exc_req, rst_req}, 0);
  endtask

  initial begin
    logic [7:0] d;
    int t0, t1, td, n;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    t0 = cyc;
    rd(2'd0, d); chk(d == 8'hB1, "R1 ctrl after power-on", d, 8'hB1);
    rd(2'd2, d); chk(d == 8'h00, "R6 status after power-on", d, 0);
    chk(!rst_req && !exc_req, "R1 no request after reset", req_cnt, 0);
    wait_req(t0, period(PM), 1'b0, "R1 first expiry", td);
    rd(2'd2, d); chk(d == 8'h01, "R6 status set on expiry", d, 1);

    rd(2'd1, d); chk(d == 8'h00, "R10 kick address reads zero", d, 0);
    rd(2'd3, d); chk(d == 8'h00, "R10 unused address reads zero", d, 0);

    for (int s = 0; s < 16; s++) begin
      wr(2'd0, {s[3:0], 4'h1});
      rd(2'd0, d); chk(d == {s[3:0], 4'h1}, "R2 select readback", d, {s[3:0], 4'h1});
      wr(2'd1, 8'h00);
      t0 = cyc;
      wait_req(t0, period(s), 1'b0, $sformatf("R2 R4 sel=%0d", s), td);
    end

    wr(2'd0, 8'h31);
    wr(2'd1, 8'h00);
    n = req_cnt;
    for (int k = 0; k < 10; k++) begin
      repeat (20) @(negedge clk);
      wr(2'd1, 8'h5A);
    end
    t0 = cyc;
    chk(req_cnt == n, "R3 kicks hold off expiry", req_cnt - n, 0);
    wait_req(t0, 32, 1'b0, "R3 expiry after last kick", td);

    wr(2'd0, 8'h33);
    wr(2'd1, 8'h00);
    t0 = cyc;
    wait_req(t0, 32, 1'b1, "R5 exception mode", td);
    wait_req(td, 32, 1'b1, "R11 back-to-back expiry", t1);

    wr(2'd0, 8'h41);
    wr(2'd1, 8'h00);
    t0 = cyc;
    repeat (20) @(negedge clk);
    wr(2'd0, 8'h41);
    wait_req(t0, 64, 1'b0, "R9 same select keeps count", td);
    wr(2'd1, 8'h00);
    repeat (20) @(negedge clk);
    wr(2'd0, 8'h31);
    t0 = cyc;
    wait_req(t0, 32, 1'b0, "R9 new select restarts", td);

    wr(2'd0, 8'h30);
    n = req_cnt;
    repeat (200) @(negedge clk);
    chk(req_cnt == n, "R7 disabled gives no request", req_cnt - n, 0);
    wr(2'd0, 8'h31);
    t0 = cyc;
    wait_req(t0, 32, 1'b0, "R7 full period after enable", td);

    wr(2'd1, 8'h00);
    t0 = cyc;
    repeat (10) @(negedge clk);
    sleep = 1'b1;
    repeat (15) @(negedge clk);
    sleep = 1'b0;
    repeat (5) @(negedge clk);
    halt = 1'b1;
    repeat (9) @(negedge clk);
    halt = 1'b0;
    wait_req(t0, 32 + 15 + 9, 1'b0, "R8 pause stretches period", td);
    wr(2'd1, 8'h00);
    t0 = cyc;
    sleep = 1'b1;
    n = req_cnt;
    repeat (100) @(negedge clk);
    chk(req_cnt == n, "R8 no request while asleep", req_cnt - n, 0);
    sleep = 1'b0;
    t1 = cyc;
    wait_req(t1, 32, 1'b0, "R8 resume after sleep", td);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(2'd2, d); chk(d == 8'h01, "R6 status survives chip reset", d, 1);
    rd(2'd0, d); chk(d == 8'hB1, "R1 ctrl after chip reset", d, 8'hB1);
    wr(2'd2, 8'h01);
    rd(2'd2, d); chk(d == 8'h00, "R6 write-one clears status", d, 0);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
    t0 = cyc;
    wait_req(t0, 4, 1'b0, "R2 shortest period", td);
    rd(2'd2, d); chk(d == 8'h01, "R6 status set again", d, 1);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    rd(2'd2, d); chk(d == 8'h00, "R6 power-on clears status", d, 0);

    wr(2'd0, 8'h23);
    repeat (3) @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    t0 = cyc;
    rd(2'd0, d); chk(d == 8'hB1, "R1 ctrl after wake", d, 8'hB1);
    wait_req(t0, period(PM), 1'b0, "R1 longest period after wake", td);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule